// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block performs one integer operation per accepted strobe on two operands at a selectable width of a quarter, a half or the whole data path (8, 16 or 32 bits at the default width). It supports addition, addition with carry, subtraction, subtraction with borrow, compare, bitwise AND, OR and XOR, and increment and decrement of the first operand. One cycle after the strobe it presents a registered result together with six status flags: overflow, sign, zero, auxiliary (nibble) carry, parity and carry.

Each operation also reports a flag write-enable vector. A surrounding flags register merges the new flag values under that vector. The operation also reports whether the result is meant to be stored. Compare produces flags only. Increment and decrement leave the carry flag untouched. The incoming carry is read only by the carry-using add and the borrow-using subtract.

Top module: `flag_alu`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise. While `rst` is high, every output is cleared to zero at the clock edge.
- R2: The `size` field selects the operation width: 0 = 8 bits, 1 = 16 bits, 2 and 3 = 32 bits. Operand bits above the selected width are ignored, and `result` bits above it are zero.
- R3: Flag vector positions are: bit 5 = O, bit 4 = S, bit 3 = Z, bit 2 = A, bit 1 = P, bit 0 = C. For the op codes ADD=0, ADC=2, SUB=5, SBB=3 and CMP=7, C is the carry (add) or borrow (subtract) out of the selected width. A is the carry or borrow out of bit 3 into bit 4. All six bits of `flag_we` are high.
- R4: For addition, O is set when both operands have the same sign and the result's sign differs. For subtraction, O is set when the operand signs differ and the result's sign differs from the first operand's sign.
- R5: S is the result's top bit at the selected width. Z is set when the result is zero at that width. P is set when the low eight bits of the result hold an even number of ones.
- R6: ADC (2) and SBB (3) add `carry_in` as an extra addend or borrow. Every other operation gives the same outputs whatever `carry_in` is.
- R7: AND=4, OR=1 and XOR=6 produce the bitwise result with O, C and A driven to 0. S, Z and P come from the result, and `flag_we` is all ones.
- R8: INC=8 adds 1 to `opa` and DEC=9 subtracts 1 from it, with O, S, Z, A and P computed as for addition or subtraction. The C output bit is 0 and `flag_we` is 6'b111110.
- R9: CMP drives `result` with the difference but holds `result_we` low. Every other supported operation raises `result_we`.
- R10: Op codes 10 to 15 are unsupported and produce `result`, `flags`, `flag_we` and `result_we` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| size | input | 2 | Width select |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| carry_in | input | 1 | Incoming carry or borrow flag |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | DATA_W | Result, zero above the selected width |
| result_we | output | 1 | Result is to be stored |
| flags | output | 6 | O, S, Z, A, P, C from bit 5 down to bit 0 |
| flag_we | output | 6 | Flag write-enable mask, same bit order |

## Verification
On every cycle the properties check the strobe timing, zero upper result bits at 8-bit width, and parity and zero flags consistent with the result. They also check that logical operations clear O, A and C, that increment and decrement mask the carry, that compare never stores, and that unsupported codes produce nothing. The exact arithmetic values can be shown only by the bench's scenarios against an independent signed and unsigned model. These values are the carry and borrow at each width, the nibble carry, the overflow boundaries at the sign limits, and carry-in acting only on ADC and SBB.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_OR  = 4'd1,
    OP_ADC = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_SUB = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2
  } logic_fn_e;

  localparam int NFLAGS = 6;
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  typedef struct packed {
    logic      known;
    logic      is_logic;
    logic      is_sub;
    logic      use_cin;
    logic      incdec;
    logic      wr_result;
    logic_fn_e lfn;
  } alu_ctl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op,
  output alu_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    ctl.lfn = LF_AND;
    unique case (op)
      OP_ADD: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; end
      OP_ADC: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.use_cin = 1'b1; end
      OP_SUB: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.is_sub = 1'b1; end
      OP_SBB: begin
        ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.is_sub = 1'b1; ctl.use_cin = 1'b1;
      end
      OP_CMP: begin ctl.known = 1'b1; ctl.is_sub = 1'b1; end
      OP_INC: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.incdec = 1'b1; end
      OP_DEC: begin
        ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.incdec = 1'b1; ctl.is_sub = 1'b1;
      end
      OP_AND: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.is_logic = 1'b1; ctl.lfn = LF_AND; end
      OP_OR:  begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.is_logic = 1'b1; ctl.lfn = LF_OR;  end
      OP_XOR: begin ctl.known = 1'b1; ctl.wr_result = 1'b1; ctl.is_logic = 1'b1; ctl.lfn = LF_XOR; end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_ctl_t          ctl,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              aux,
  output logic              ovf,
  output logic              sign
);
  localparam int W_Q = DATA_W / 4;
  localparam int W_H = DATA_W / 2;

  logic [DATA_W-1:0] mask, a_m, b_m, logic_res, arith_res;
  logic [DATA_W:0]   ext_sum, ci_ext;
  logic              ci, sa, sb, sr;

  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    top_bit = v[W_Q-1];
      2'd1:    top_bit = v[W_H-1];
      default: top_bit = v[DATA_W-1];
    endcase
  endfunction

  always_comb begin
    case (size)
      2'd0:    mask = {{(DATA_W-W_Q){1'b0}}, {W_Q{1'b1}}};
      2'd1:    mask = {{(DATA_W-W_H){1'b0}}, {W_H{1'b1}}};
      default: mask = {DATA_W{1'b1}};
    endcase
  end

  assign a_m    = opa & mask;
  assign b_m    = (ctl.incdec ? {{(DATA_W-1){1'b0}}, 1'b1} : opb) & mask;
  assign ci     = ctl.use_cin & carry_in;
  assign ci_ext = {{DATA_W{1'b0}}, ci};

  assign ext_sum = ctl.is_sub ? ({1'b0, a_m} - {1'b0, b_m} - ci_ext)
                              : ({1'b0, a_m} + {1'b0, b_m} + ci_ext);
  assign arith_res = ext_sum[DATA_W-1:0] & mask;

  always_comb begin
    case (ctl.lfn)
      LF_OR:   logic_res = a_m | b_m;
      LF_XOR:  logic_res = a_m ^ b_m;
      default: logic_res = a_m & b_m;
    endcase
  end

  always_comb begin
    case (size)
      2'd0:    carry = ext_sum[W_Q];
      2'd1:    carry = ext_sum[W_H];
      default: carry = ext_sum[DATA_W];
    endcase
  end

  assign aux  = a_m[4] ^ b_m[4] ^ ext_sum[4];
  assign sa   = top_bit(a_m, size);
  assign sb   = top_bit(b_m, size);
  assign sr   = top_bit(arith_res, size);
  assign ovf  = ctl.is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  assign res  = ctl.is_logic ? logic_res : arith_res;
  assign sign = top_bit(res, size);
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_ctl_t          ctl,
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              aux,
  input  logic              ovf,
  input  logic              sign,
  output logic [NFLAGS-1:0] fl,
  output logic [NFLAGS-1:0] fl_we
);
  always_comb begin
    fl    = '0;
    fl_we = '0;
    if (ctl.known) begin
      fl[FL_S] = sign;
      fl[FL_Z] = (res == '0);
      fl[FL_P] = ~^res[7:0];
      fl_we    = '1;
      if (!ctl.is_logic) begin
        fl[FL_O] = ovf;
        fl[FL_A] = aux;
        fl[FL_C] = carry;
      end
      if (ctl.incdec) begin
        fl[FL_C]    = 1'b0;
        fl_we[FL_C] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [5:0]        flags,
  output logic [5:0]        flag_we
);
  alu_ctl_t          ctl;
  logic [DATA_W-1:0] dp_res;
  logic              dp_c, dp_a, dp_o, dp_s;
  logic [NFLAGS-1:0] nx_fl, nx_we;

  alu_decode u_dec (.op(op), .ctl(ctl));

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl(ctl), .size(size), .opa(opa), .opb(opb), .carry_in(carry_in),
    .res(dp_res), .carry(dp_c), .aux(dp_a), .ovf(dp_o), .sign(dp_s)
  );

  alu_flags #(.DATA_W(DATA_W)) u_fl (
    .ctl(ctl), .res(dp_res), .carry(dp_c), .aux(dp_a), .ovf(dp_o), .sign(dp_s),
    .fl(nx_fl), .fl_we(nx_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      flags     <= '0;
      flag_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= ctl.known ? dp_res : '0;
        result_we <= ctl.wr_result;
        flags     <= nx_fl;
        flag_we   <= nx_we;
      end
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [1:0]        size,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic [5:0]        flags,
  input logic [5:0]        flag_we
);
  p_latency_r1: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_idle_r1:    assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(size) == 2'd0) |-> (result[DATA_W-1:DATA_W/4] == '0));

  p_parity_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) <= 4'd9) |-> (flags[1] == ~^result[7:0]));
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) <= 4'd9) |-> (flags[3] == (result == '0)));

  p_logic_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(op) == 4'd1 || $past(op) == 4'd4 || $past(op) == 4'd6))
    |-> (flags[5] == 1'b0 && flags[2] == 1'b0 && flags[0] == 1'b0 && flag_we == 6'b111111));

  p_incdec_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(op) == 4'd8 || $past(op) == 4'd9)) |-> (flag_we == 6'b111110));

  p_cmp_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) == 4'd7) |-> !result_we);

  p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) >= 4'd10)
    |-> (result == '0 && flags == 6'd0 && flag_we == 6'd0 && !result_we));
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
  .out_valid(out_valid), .result(result), .result_we(result_we),
  .flags(flags), .flag_we(flag_we)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [31:0] opa, opb;
  logic        carry_in;
  logic        out_valid, result_we;
  logic [31:0] result;
  logic [5:0]  flags, flag_we;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] res;
    logic        rwe;
    logic [5:0]  fl;
    logic [5:0]  fwe;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  flag_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .opa(opa), .opb(opb), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .result_we(result_we), .flags(flags), .flag_we(flag_we)
  );

  always #2 clk = ~clk;

  function automatic exp_t model(input logic [3:0] o, input logic [1:0] s,
                                 input logic [31:0] a, input logic [31:0] b, input logic ci);
    exp_t e;
    int w;
    longint unsigned m, am, bm, r, cin, half;
    longint sa, sb, sfull;
    logic c, ax, ov, sub;
    e.res = '0; e.rwe = 1'b0; e.fl = '0; e.fwe = '0; e.tag = "";
    w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    am = a & m;
    bm = (o == 4'd8 || o == 4'd9) ? 64'd1 : (b & m);
    cin = (o == 4'd2 || o == 4'd3) ? {63'd0, ci} : 64'd0;
    sa = (am >= half) ? longint'(am) - longint'(m) - 1 : longint'(am);
    sb = (bm >= half) ? longint'(bm) - longint'(m) - 1 : longint'(bm);
    c = 0; ax = 0; ov = 0; r = 0;
    if (o > 4'd9) return e;
    sub = (o == 4'd3 || o == 4'd5 || o == 4'd7 || o == 4'd9);
    if (o == 4'd1 || o == 4'd4 || o == 4'd6) begin
      r = (o == 4'd1) ? (am | bm) : (o == 4'd4) ? (am & bm) : (am ^ bm);
    end else if (sub) begin
      r  = (am - bm - cin) & m;
      c  = am < bm + cin;
      ax = (am & 15) < (bm & 15) + cin;
      sfull = sa - sb - longint'(cin);
      ov = sfull >= longint'(half) || sfull < -longint'(half);
    end else begin
      r  = (am + bm + cin) & m;
      c  = (am + bm + cin) > m;
      ax = ((am & 15) + (bm & 15) + cin) > 15;
      sfull = sa + sb + longint'(cin);
      ov = sfull >= longint'(half) || sfull < -longint'(half);
    end
    e.res = r[31:0];
    e.rwe = (o != 4'd7);
    e.fl[5] = ov;
    e.fl[4] = r[w-1];
    e.fl[3] = (r == 0);
    e.fl[2] = ax;
    e.fl[1] = ($countones(r[7:0]) % 2) == 0;
    e.fl[0] = (o == 4'd8 || o == 4'd9) ? 1'b0 : c;
    e.fwe = (o == 4'd8 || o == 4'd9) ? 6'b111110 : 6'b111111;
    return e;
  endfunction

  task automatic send(input logic [3:0] o, input logic [1:0] s, input logic [31:0] a,
                      input logic [31:0] b, input logic ci, input string tag);
    exp_t e;
    e = model(o, s, a, b, ci);
    e.tag = tag;
    sb_q.push_back(e);
    op = o; size = s; opa = a; opb = b; carry_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R1: out_valid with no pending operation (actual 1, expected 0)");
      end else begin
        e = sb_q.pop_front();
        if (result !== e.res || result_we !== e.rwe || flags !== e.fl || flag_we !== e.fwe) begin
          fails++;
          $display("FAIL %s: actual res=%h we=%b fl=%b fwe=%b expected res=%h we=%b fl=%b fwe=%b",
                   e.tag, result, result_we, flags, flag_we, e.res, e.rwe, e.fl, e.fwe);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] x;
    rst = 1'b1; in_valid = 1'b0; op = '0; size = '0; opa = '0; opb = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || result_we !== 1'b0 || flags !== '0 || flag_we !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs actual v=%b r=%h f=%b expected all zero", out_valid, result, flags);
    end
    rst = 1'b0;
    @(negedge clk);

    send(4'd0, 2'd0, 32'h7F, 32'h01, 1'b0, "R4 add signed overflow 8b");
    send(4'd0, 2'd0, 32'hFF, 32'h01, 1'b0, "R3 R5 add carry zero 8b");
    send(4'd0, 2'd0, 32'h0F, 32'h01, 1'b1, "R6 add ignores carry_in");
    send(4'd2, 2'd1, 32'hFFFF, 32'h0, 1'b1, "R6 adc carry 16b");
    send(4'd5, 2'd2, 32'h0, 32'h1, 1'b0, "R3 sub borrow 32b");
    send(4'd3, 2'd0, 32'h10, 32'h0F, 1'b1, "R6 sbb borrow in 8b");
    send(4'd5, 2'd0, 32'h80, 32'h01, 1'b1, "R4 sub overflow 8b ignores carry_in");
    send(4'd7, 2'd1, 32'h1234, 32'h1235, 1'b0, "R9 cmp no write");
    send(4'd4, 2'd2, 32'hF0F0_FFFF, 32'h0FF0_8001, 1'b1, "R7 and");
    send(4'd1, 2'd0, 32'h00, 32'h00, 1'b1, "R7 or zero");
    send(4'd6, 2'd1, 32'hAAAA, 32'h5555, 1'b1, "R7 xor");
    send(4'd8, 2'd0, 32'hFF, 32'h77, 1'b1, "R8 inc wrap keeps C");
    send(4'd9, 2'd1, 32'h8000, 32'h0, 1'b0, "R8 dec overflow 16b");
    send(4'd0, 2'd1, 32'hABCD_1234, 32'h5678_0001, 1'b0, "R2 upper operand bits ignored");
    send(4'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, "R2 size 3 is 32b");
    send(4'd15, 2'd2, 32'h1, 32'h1, 1'b1, "R10 unsupported op");
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle out_valid actual %b expected 0", out_valid);
    end

    x = 32'h1357_9BDF;
    for (int i = 0; i < 66; i++) begin
      logic [31:0] a, b;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); a = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); b = x;
      send(4'(i % 11), 2'((i / 11) % 4), a, b, x[7], "R3 R5 sweep");
      if (i % 7 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule